// File: doc/BRIEF.md
# Line Loss-of-Signal Detector

This block watches a received line one bit interval at a time and decides whether the signal has been lost. Each interval arrives as a one-cycle strobe. The strobe carries a mark flag, which says whether a pulse was seen in that interval. It also carries a level-OK flag from the analog front end, which says whether the amplitude was above threshold. The front end applies a lower threshold while loss is inactive and a higher one while loss is active, so the same flag carries both meanings. That hysteresis lives outside this block.

Loss is declared after a run of consecutive low-level intervals. The length of that run is chosen by a criterion select. Loss is cleared only at the end of a 128-interval block, and only if three things held in that block: every interval had good level, enough marks were seen, and no long run of zeros occurred. While loss is active, the block can force its receive data output to ones. It can also ask the transmit path to send all ones.

The strobe interface has no back-pressure. The line produces one interval per strobe and cannot be stalled, so there is no ready signal and every strobe is consumed in the cycle it is presented. Cycles without a strobe have no effect.

Top module: `line_los_detector`

## Requirements
- R1: With `crit_sel` = 0, `los_o` rises at the clock edge that takes the 175th consecutive strobe with `level_ok` = 0. It stays low through the 174th such strobe if it was low before.
- R2: With `crit_sel` = 1, `los_o` rises on the 1544th consecutive low-level strobe and not before.
- R3: Strobes are grouped into non-overlapping blocks of 128, counted from reset. `los_o` can fall only at the edge that takes the last strobe of a block. It falls there only if the block held at least 16 marks (1/8 density). A block with 15 marks leaves loss set.
- R4: A block that contains a run of 100 or more consecutive zero-mark strobes does not clear loss. A longest run of 99 zeros does not prevent clearing.
- R5: A block in which any strobe had `level_ok` = 0 does not clear loss.
- R6: A strobe with `level_ok` = 1 restarts the low-level run. A later declare needs a full new run of consecutive low strobes.
- R7: Cycles with `bit_valid` = 0 change no counter and no output state, whatever the other inputs are.
- R8: After reset, `los_o` is 1. It is cleared only through the rule in R3 to R5.
- R9: `rx_data_o` equals `bit_mark`, except that it is 1 when `rx_sub_en` = 1 and `los_o` = 1.
- R10: `tx_ones_req_o` is 1 exactly when `tx_sub_en` = 1 and `los_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_valid | input | 1 | One-cycle strobe marking one bit interval |
| bit_mark | input | 1 | 1 when a mark was received in the interval |
| level_ok | input | 1 | 1 when the line level was above threshold in the interval |
| crit_sel | input | 1 | Declare run length: 0 selects 175, 1 selects 1544 |
| rx_sub_en | input | 1 | Enables forcing receive data to ones during loss |
| tx_sub_en | input | 1 | Enables the transmit all-ones request during loss |
| los_o | output | 1 | Loss-of-signal flag |
| rx_data_o | output | 1 | Receive data after substitution |
| tx_ones_req_o | output | 1 | Request to transmit all ones |

## Verification
The clear rule is exercised with whole 128-strobe blocks that start from reset. The mark densities used are exactly 1/8, just under 1/8 and all ones, which separates the density threshold from a plain "any marks" test. Zero runs of 99 and 100 sit on either side of the run limit, and a single low-level strobe in an otherwise clean block isolates the level condition. Both declare counts are hit at one strobe short and exactly on count. A good-level strobe placed mid-run and idle cycles placed mid-run show that the counter restarts on good level and that cycles without a strobe are ignored.

// File: rtl/los_pkg.sv
package los_pkg;
  // Outcome of one evaluation block, valid on the last strobe of the block
  typedef struct packed {
    logic blk_end;
    logic blk_pass;
  } blk_verdict_t;
endpackage

// File: rtl/los_declare_counter.sv
module los_declare_counter #(
  parameter int SHORT_RUN = 175,
  parameter int LONG_RUN  = 1544
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic level_ok,
  input  logic crit_sel,
  output logic declare
);
  localparam int CW = $clog2(LONG_RUN + 1);

  logic [CW-1:0] low_run;
  logic [CW-1:0] limit;

  assign limit   = crit_sel ? CW'(LONG_RUN) : CW'(SHORT_RUN);
  assign declare = strobe && !level_ok && ((low_run + CW'(1)) >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run <= '0;
    end else if (strobe) begin
      if (level_ok)
        low_run <= '0;
      else if (low_run != CW'(LONG_RUN))
        low_run <= low_run + CW'(1);
    end
  end

  // R1
  declare_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    declare |-> (strobe && !level_ok));

  // R6
  run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= CW'(LONG_RUN));
endmodule

// File: rtl/los_clear_window.sv
module los_clear_window
  import los_pkg::*;
#(
  parameter int WIN_LEN    = 128,
  parameter int MIN_MARKS  = 16,
  parameter int ZRUN_LIMIT = 100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         mark,
  input  logic         level_ok,
  output blk_verdict_t verdict
);
  localparam int IW = $clog2(WIN_LEN);
  localparam int MW = $clog2(WIN_LEN + 1);
  localparam int RW = $clog2(ZRUN_LIMIT + 1);

  logic [IW-1:0] idx;
  logic [MW-1:0] marks, marks_n;
  logic [RW-1:0] zrun, zrun_n;
  logic          run_bad, run_bad_n;
  logic          lvl_bad, lvl_bad_n;
  logic          last;

  assign last    = (idx == IW'(WIN_LEN - 1));
  assign marks_n = marks + MW'(mark);
  assign zrun_n  = mark ? '0 : ((zrun == RW'(ZRUN_LIMIT)) ? zrun : zrun + RW'(1));
  assign run_bad_n = run_bad || (zrun_n >= RW'(ZRUN_LIMIT));
  assign lvl_bad_n = lvl_bad || !level_ok;

  assign verdict.blk_end  = strobe && last;
  assign verdict.blk_pass = (marks_n >= MW'(MIN_MARKS)) && !run_bad_n && !lvl_bad_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx     <= '0;
      marks   <= '0;
      zrun    <= '0;
      run_bad <= 1'b0;
      lvl_bad <= 1'b0;
    end else if (strobe) begin
      if (last) begin
        idx     <= '0;
        marks   <= '0;
        zrun    <= '0;
        run_bad <= 1'b0;
        lvl_bad <= 1'b0;
      end else begin
        idx     <= idx + IW'(1);
        marks   <= marks_n;
        zrun    <= zrun_n;
        run_bad <= run_bad_n;
        lvl_bad <= lvl_bad_n;
      end
    end
  end

  // R3
  block_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && last) |=> (idx == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(idx) && $stable(marks));
endmodule

// File: rtl/los_state.sv
module los_state
  import los_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         declare,
  input  blk_verdict_t verdict,
  output logic         los
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      los <= 1'b1;
    else if (declare)
      los <= 1'b1;
    else if (verdict.blk_end && verdict.blk_pass)
      los <= 1'b0;
  end
endmodule

// File: rtl/line_los_detector.sv
module line_los_detector
  import los_pkg::*;
#(
  parameter int SHORT_RUN  = 175,
  parameter int LONG_RUN   = 1544,
  parameter int WIN_LEN    = 128,
  parameter int MIN_MARKS  = WIN_LEN / 8,
  parameter int ZRUN_LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_mark,
  input  logic level_ok,
  input  logic crit_sel,
  input  logic rx_sub_en,
  input  logic tx_sub_en,
  output logic los_o,
  output logic rx_data_o,
  output logic tx_ones_req_o
);
  logic         declare;
  blk_verdict_t verdict;

  los_declare_counter #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) u_decl (
    .clk(clk), .rst_n(rst_n), .strobe(bit_valid), .level_ok(level_ok),
    .crit_sel(crit_sel), .declare(declare)
  );

  los_clear_window #(.WIN_LEN(WIN_LEN), .MIN_MARKS(MIN_MARKS), .ZRUN_LIMIT(ZRUN_LIMIT)) u_win (
    .clk(clk), .rst_n(rst_n), .strobe(bit_valid), .mark(bit_mark),
    .level_ok(level_ok), .verdict(verdict)
  );

  los_state u_state (
    .clk(clk), .rst_n(rst_n), .declare(declare), .verdict(verdict), .los(los_o)
  );

  assign rx_data_o     = bit_mark || (rx_sub_en && los_o);
  assign tx_ones_req_o = tx_sub_en && los_o;

  // R1 R2
  los_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_o) |-> $past(bit_valid && !level_ok));

  // R3
  los_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_o) |-> $past(verdict.blk_end && level_ok));

  // R9
  rx_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sub_en && los_o) |-> rx_data_o);

  // R10
  tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ones_req_o |-> (los_o && tx_sub_en));
endmodule

// File: tb/test_line_los_detector.sv
module test_line_los_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_mark = 1'b0, level_ok = 1'b0;
  logic crit_sel = 1'b0, rx_sub_en = 1'b0, tx_sub_en = 1'b0;
  logic los_o, rx_data_o, tx_ones_req_o;
  int   n_chk = 0, n_fail = 0, n_strb = 0;

  always #10 clk = ~clk;

  line_los_detector i_line_los_detector (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_mark(bit_mark),
    .level_ok(level_ok), .crit_sel(crit_sel), .rx_sub_en(rx_sub_en),
    .tx_sub_en(tx_sub_en), .los_o(los_o), .rx_data_o(rx_data_o),
    .tx_ones_req_o(tx_ones_req_o)
  );

  // Block vectors: {mark period, zero-gap start, zero-gap length, bad-level index, expected los}
  localparam logic [32:0] VEC [7] = '{
    {8'd8,  8'd255, 8'd0,   8'd255, 1'b0},  // R3 exactly 16 marks
    {8'd9,  8'd255, 8'd0,   8'd255, 1'b1},  // R3 15 marks
    {8'd1,  8'd255, 8'd0,   8'd255, 1'b0},  // R3 all ones
    {8'd1,  8'd10,  8'd99,  8'd255, 1'b0},  // R4 run of 99
    {8'd1,  8'd10,  8'd100, 8'd255, 1'b1},  // R4 run of 100
    {8'd1,  8'd255, 8'd0,   8'd64,  1'b1},  // R5 one low-level strobe
    {8'd16, 8'd255, 8'd0,   8'd255, 1'b1}   // R3 8 marks
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bit_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    n_strb = 0;
  endtask

  task automatic strobe(input logic m, input logic lv);
    @(negedge clk);
    bit_valid = 1'b1; bit_mark = m; level_ok = lv;
    @(posedge clk); #1;
    bit_valid = 1'b0;
    n_strb++;
  endtask

  task automatic lows(input int n);
    for (int k = 0; k < n; k++) strobe(1'b0, 1'b0);
  endtask

  task automatic clear_loss(input string req);
    while (n_strb % 128 != 0) strobe(1'b1, 1'b1);
    for (int k = 0; k < 128; k++) strobe(1'b1, 1'b1);
    chk(req, los_o, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R8 reset state and substitution during loss
    do_reset();
    #1;
    chk("R8 reset los", los_o, 1'b1);
    tx_sub_en = 1'b1; rx_sub_en = 1'b1; bit_mark = 1'b0; #1;
    chk("R10 req at reset", tx_ones_req_o, 1'b1);
    chk("R9 forced ones", rx_data_o, 1'b1);
    rx_sub_en = 1'b0; tx_sub_en = 1'b0; #1;
    chk("R9 no force", rx_data_o, 1'b0);
    chk("R10 no req", tx_ones_req_o, 1'b0);

    // Table walk over clear-rule blocks
    for (int e = 0; e < 7; e++) begin
      do_reset();
      for (int i = 0; i < 128; i++) begin
        logic m;
        m = ((i % int'(VEC[e][32:25])) == 0);
        if (i >= int'(VEC[e][24:17]) && i < int'(VEC[e][24:17]) + int'(VEC[e][16:9])) m = 1'b0;
        strobe(m, (i != int'(VEC[e][8:1])));
        if (i == 126) chk("R3 no clear mid-block", los_o, 1'b1);
      end
      chk("R3 R4 R5 block verdict", los_o, VEC[e][0]);
    end

    // Short declare with restart by good level
    do_reset();
    clear_loss("R3 clear before short");
    crit_sel = 1'b0;
    lows(100); strobe(1'b0, 1'b1); lows(174);
    chk("R6 restart count", los_o, 1'b0);
    lows(1);
    chk("R1 declare at 175", los_o, 1'b1);

    // Idle cycles do not count
    clear_loss("R3 clear before idle");
    lows(174);
    @(negedge clk); level_ok = 1'b0; bit_mark = 1'b0;
    repeat (20) @(posedge clk); #1;
    chk("R7 idle ignored", los_o, 1'b0);
    chk("R1 one short", los_o, 1'b0);
    lows(1);
    chk("R1 declare after idle", los_o, 1'b1);

    // Long declare
    clear_loss("R3 clear before long");
    rx_sub_en = 1'b1; bit_mark = 1'b0; #1;
    chk("R9 no force when clear", rx_data_o, 1'b0);
    bit_mark = 1'b1; #1;
    chk("R9 pass mark", rx_data_o, 1'b1);
    rx_sub_en = 1'b0;
    crit_sel = 1'b1;
    lows(1543);
    chk("R2 not before 1544", los_o, 1'b0);
    lows(1);
    chk("R2 declare at 1544", los_o, 1'b1);
    tx_sub_en = 1'b1; #1;
    chk("R10 req in loss", tx_ones_req_o, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule